// File: doc/BRIEF.md
# Programmable Synchronous Serial Port (Master/Slave)

This block is a full-duplex synchronous serial port that moves one 8-bit word at a time. It shifts a transmit byte out and collects a receive byte in over the same clock edges. The two roles are selected by a mode bit. As bus master, the port generates the serial clock from the system clock and drives one of three active-low device-select outputs. As slave, it follows an external clock once an external active-low select input goes low.

Two registers are written over a simple strobe interface. The divisor register sets the master clock speed. The control register sets clock polarity, clock phase, role and which select output to use. In master mode a transfer starts when `txValid` is sampled while the port is idle. In slave mode a transfer starts on the falling edge of the external select. At the end of every word, `done` pulses with the received byte on `rxByte`.

Top module: `spi_port`

## Requirements
- R1: A write to address 0 stores the 16-bit divisor, and any value below 2 is stored as 2. In master mode each serial-clock half-period lasts exactly divisor system-clock cycles, so the serial clock runs at f_clk / (2 × divisor).
- R2: While no master transfer runs, `sckOut` rests at the polarity bit, which is bit 0 of the control register (address 1).
- R3: With phase bit 1 of control equal to 0, the master shifts 8 bits MSB first. It presents each MOSI bit before the leading clock edge, samples `misoIn` on leading edges and changes MOSI on trailing edges. The word sent and the word received are exchanged over the same 16 edges.
- R4: With the phase bit equal to 1, data changes on leading edges and is sampled on trailing edges. The MSB is on the line before the first edge.
- R5: Control bits [4:3] choose the select line (0, 1 or 2 drives `selN[index]` low; 3 drives none). The chosen line falls one half-period before the first clock edge and rises one half-period after the last edge. At most one select line is low at any time, and none is low while the port is idle.
- R6: `busy` is high from the accepted start until the end of the word. `txValid` seen while busy starts nothing and does not change the byte in flight. `done` is high for exactly one cycle per word, and `rxByte` holds the received byte in that cycle.
- R7: With the role bit (control bit 2) equal to 0, a low `ssInN` enables the port. `sckIn` and `ssInN` pass through two flops before edge detection. The port samples `mosiIn`, drives `txByte` MSB first on `misoOut` with the same phase rules, and pulses `done` after the 16th external edge.
- R8: In slave mode all three select outputs stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = divisor, 1 = control |
| wrData | input | 16 | Register write data |
| txValid | input | 1 | Start request (master mode) |
| txByte | input | 8 | Byte to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rxByte | output | 8 | Received byte |
| sckOut | output | 1 | Serial clock driven as master |
| mosiOut | output | 1 | Serial data out as master |
| misoIn | input | 1 | Serial data in as master |
| selN | output | 3 | Active-low device selects |
| ssInN | input | 1 | Active-low select input as slave |
| sckIn | input | 1 | External serial clock as slave |
| mosiIn | input | 1 | Serial data in as slave |
| misoOut | output | 1 | Serial data out as slave |

## Verification
Two things happen on the same system-clock edge in master mode: the last half-period ends, so the select line rises, and `done` pulses with the completed byte. The bench stands in for the remote device on every clock edge. It checks that the select release, the fall of `busy` and the `done` pulse all show up in one sampling point, exactly one divisor after the final clock edge. A second start request is injected mid-word, where it would clash with the shift in progress. The bench then judges that the byte received by the model and the single `done` pulse are unchanged.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef struct packed {
    logic load;    // capture txByte into the shifter
    logic sample;  // shift the input line into the receive register
    logic shift;   // advance the transmit shifter
  } dpStrobe_t;

  localparam logic ADDR_DIVISOR = 1'b0;
  localparam logic ADDR_CONTROL = 1'b1;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [DIV_W-1:0]   wrData,
  input  logic               txValid,
  input  logic               ssInN,
  input  logic               sckIn,
  output dpStrobe_t          strobe,
  output logic               isMaster,
  output logic               busy,
  output logic               done,
  output logic               sckOut,
  output logic [NUM_SEL-1:0] selN
);
  localparam int SEL_W = $clog2(NUM_SEL + 1);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES + 2);
  localparam logic [CNT_W-1:0] EDGE_WORD = CNT_W'(EDGES);
  localparam logic [CNT_W-1:0] EDGE_TAIL = CNT_W'(EDGES + 1);
  localparam logic [DIV_W-1:0] DIV_MIN   = DIV_W'(2);

  logic [DIV_W-1:0] divReg, halfCnt;
  logic             cpol, cpha, masterMode;
  logic [SEL_W-1:0] selIdx;
  logic [1:0]       ssPipe, sckPipe;
  logic             ssPrev, sckPrev;
  logic             running, sckReg, doneReg;
  logic [CNT_W-1:0] edgeCnt, nextEdge;
  logic             ssSync, sckSync, startM, ssFall, slaveAct;
  logic             tick, evt, inWord, lastM, lastS;

  always_comb begin
    ssSync   = ssPipe[1];
    sckSync  = sckPipe[1];
    startM   = masterMode && txValid && !running;
    ssFall   = !masterMode && ssPrev && !ssSync;
    slaveAct = !masterMode && !ssSync;
    tick     = running && (halfCnt == '0);
    evt      = masterMode ? tick : (slaveAct && !ssFall && (sckSync != sckPrev));
    nextEdge = edgeCnt + 1'b1;
    inWord   = nextEdge <= EDGE_WORD;
    lastM    = tick && (nextEdge == EDGE_TAIL);
    lastS    = evt && !masterMode && (nextEdge == EDGE_WORD);
    strobe.load   = startM || ssFall;
    strobe.sample = evt && inWord && (cpha ? !nextEdge[0] : nextEdge[0]);
    strobe.shift  = evt && inWord &&
                    (cpha ? (nextEdge[0] && (nextEdge != CNT_W'(1))) : !nextEdge[0]);
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg     <= DIV_MIN;
      cpol       <= 1'b0;
      cpha       <= 1'b0;
      masterMode <= 1'b0;
      selIdx     <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_DIVISOR) begin
        divReg <= (wrData < DIV_MIN) ? DIV_MIN : wrData;
      end else begin
        cpol       <= wrData[0];
        cpha       <= wrData[1];
        masterMode <= wrData[2];
        selIdx     <= wrData[3 +: SEL_W];
      end
    end
  end

  // two-flop synchronizers for the slave-side inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssPipe  <= 2'b11;
      sckPipe <= 2'b00;
      ssPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      ssPipe  <= {ssPipe[0], ssInN};
      sckPipe <= {sckPipe[0], sckIn};
      ssPrev  <= ssSync;
      sckPrev <= sckSync;
    end
  end

  // transfer sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckReg  <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= lastM || lastS;
      if (startM) begin
        running <= 1'b1;
        halfCnt <= divReg - 1'b1;
      end else if (tick) begin
        halfCnt <= divReg - 1'b1;
        if (lastM) running <= 1'b0;
      end else if (running) begin
        halfCnt <= halfCnt - 1'b1;
      end
      if (strobe.load) edgeCnt <= '0;
      else if (evt)    edgeCnt <= nextEdge;
      if (!running)             sckReg <= cpol;
      else if (tick && inWord)  sckReg <= ~sckReg;
    end
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : gSel
    assign selN[i] = !(running && (selIdx == SEL_W'(i)));
  end

  assign isMaster = masterMode;
  assign busy     = running || slaveAct;
  assign done     = doneReg;
  assign sckOut   = sckReg;
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              isMaster,
  input  logic [DATA_W-1:0] txByte,
  input  logic              misoIn,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              misoOut,
  output logic [DATA_W-1:0] rxByte
);
  logic [DATA_W-1:0] txSr, rxSr;
  logic              inBit;

  assign inBit = isMaster ? misoIn : mosiIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr <= '0;
      rxSr <= '0;
    end else begin
      if (strobe.load)       txSr <= txByte;
      else if (strobe.shift) txSr <= {txSr[DATA_W-2:0], 1'b0};
      if (strobe.sample)     rxSr <= {rxSr[DATA_W-2:0], inBit};
    end
  end

  assign mosiOut = txSr[DATA_W-1];
  assign misoOut = txSr[DATA_W-1];
  assign rxByte  = rxSr;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [DIV_W-1:0]   wrData,
  input  logic               txValid,
  input  logic [DATA_W-1:0]  txByte,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rxByte,
  output logic               sckOut,
  output logic               mosiOut,
  input  logic               misoIn,
  output logic [NUM_SEL-1:0] selN,
  input  logic               ssInN,
  input  logic               sckIn,
  input  logic               mosiIn,
  output logic               misoOut
);
  dpStrobe_t strobe;
  logic      isMaster;

  spi_port_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txValid(txValid), .ssInN(ssInN), .sckIn(sckIn), .strobe(strobe),
    .isMaster(isMaster), .busy(busy), .done(done), .sckOut(sckOut), .selN(selN)
  );

  spi_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isMaster(isMaster),
    .txByte(txByte), .misoIn(misoIn), .mosiIn(mosiIn),
    .mosiOut(mosiOut), .misoOut(misoOut), .rxByte(rxByte)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int NUM_SEL = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic [NUM_SEL-1:0] selN
);
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~selN));

  // R5
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (selN == {NUM_SEL{1'b1}}));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind spi_port spi_port_chk #(.NUM_SEL(NUM_SEL)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .selN(selN)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic        txValid = 1'b0;
  logic [7:0]  txByte = '0;
  logic        busy, done, sckOut, mosiOut, misoOut;
  logic [7:0]  rxByte;
  logic        misoIn = 1'b0;
  logic [2:0]  selN;
  logic        ssInN = 1'b1;
  logic        sckIn = 1'b0;
  logic        mosiIn = 1'b0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txValid(txValid), .txByte(txByte), .busy(busy), .done(done), .rxByte(rxByte),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn), .selN(selN),
    .ssInN(ssInN), .sckIn(sckIn), .mosiIn(mosiIn), .misoOut(misoOut)
  );

  // {divisor, control, master tx byte, remote device byte}
  // control = {3'b0, sel[1:0], role, phase, polarity}
  localparam logic [39:0] VEC [6] = '{
    {16'd2, 8'h04, 8'hA5, 8'h3C},
    {16'd3, 8'h0D, 8'h81, 8'h7E},
    {16'd0, 8'h16, 8'h5A, 8'hC3},
    {16'd1, 8'h07, 8'hFF, 8'h00},
    {16'd4, 8'h1C, 8'h00, 8'hFF},
    {16'd5, 8'h17, 8'h96, 8'h69}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic masterXfer(input logic [15:0] div, input logic [7:0] ctl,
                            input logic [7:0] tx, input logic [7:0] slv);
    int exHalf, cyc, k, badHalf, badSel, earlyDone;
    logic cpha, prev;
    logic [7:0] mTx, mRx;
    logic [2:0] expSel;
    exHalf = (div < 2) ? 2 : int'(div);
    cpha = ctl[1];
    expSel = (ctl[4:3] == 2'd3) ? 3'b111 : ~(3'b001 << ctl[4:3]);
    wr(1'b0, div);
    wr(1'b1, {8'h00, ctl});
    @(negedge clk);
    check(sckOut == ctl[0], "R2 idle sck", sckOut, ctl[0]);
    mTx = slv; mRx = '0;
    if (!cpha) begin misoIn = mTx[7]; mTx = mTx << 1; end
    txByte = tx; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    prev = sckOut; cyc = 0; k = 0; badHalf = 0; badSel = 0; earlyDone = 0;
    while (k < 16) begin
      if (selN != expSel) badSel++;
      @(negedge clk);
      txValid = 1'b0;
      txByte = tx;
      cyc++;
      if (done) earlyDone++;
      if (sckOut != prev) begin
        k++;
        if (cyc != exHalf) badHalf++;
        cyc = 0;
        prev = sckOut;
        if (k[0] ^ cpha) mRx = {mRx[6:0], mosiOut};
        else if (k < 16) begin misoIn = mTx[7]; mTx = mTx << 1; end
        if (k == 4) begin txValid = 1'b1; txByte = ~tx; end  // R6 start while busy
      end
    end
    check(badHalf == 0, "R1 half-period", badHalf, 0);
    check(badSel == 0, "R5 select line", badSel, 0);
    check(earlyDone == 0, "R6 early done", earlyDone, 0);
    cyc = 0;
    while (!done && cyc < exHalf + 8) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == exHalf, "R5 select tail", cyc, exHalf);
    check(done && (selN == 3'b111) && !busy, "R6 done with release",
          {done, busy, selN}, {1'b1, 1'b0, 3'b111});
    check(rxByte == slv, "R6 rxByte", rxByte, slv);
    if (cpha) check(mRx == tx, "R4 mosi word", mRx, tx);
    else      check(mRx == tx, "R3 mosi word", mRx, tx);
    @(negedge clk);
    check(!done, "R6 single done", done, 0);
    check(sckOut == ctl[0], "R2 sck back idle", sckOut, ctl[0]);
  endtask

  task automatic slaveXfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] mst);
    logic cpha;
    logic [7:0] mSh, rx;
    int cyc, badSel;
    cpha = ctl[1];
    wr(1'b1, {8'h00, ctl});
    sckIn = ctl[0]; ssInN = 1'b1; txByte = tx;
    mSh = mst; rx = '0; badSel = 0;
    repeat (6) @(negedge clk);
    if (!cpha) begin mosiIn = mSh[7]; mSh = mSh << 1; end
    ssInN = 1'b0;
    repeat (8) @(negedge clk);
    check(busy == 1'b1, "R7 busy on select", busy, 1);
    for (int e = 1; e <= 16; e++) begin
      if (selN != 3'b111) badSel++;
      if (e[0] ^ cpha) rx = {rx[6:0], misoOut};
      sckIn = ~sckIn;
      if (!(e[0] ^ cpha) && e < 16) begin mosiIn = mSh[7]; mSh = mSh << 1; end
      if (e < 16) repeat (8) @(negedge clk);
    end
    cyc = 0;
    while (!done && cyc < 12) begin
      @(negedge clk);
      cyc++;
      if (selN != 3'b111) badSel++;
    end
    check(done == 1'b1, "R7 done seen", done, 1);
    check(rxByte == mst, "R7 rxByte", rxByte, mst);
    check(rx == tx, "R7 miso word", rx, tx);
    check(badSel == 0, "R8 selects high", badSel, 0);
    ssInN = 1'b1;
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R7 idle after deselect", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 1'b0, "R6 reset busy", busy, 0);
    check(done == 1'b0, "R6 reset done", done, 0);
    check(selN == 3'b111, "R5 reset selects", selN, 3'b111);
    check(sckOut == 1'b0, "R2 reset sck", sckOut, 0);
    // txValid in reset (slave) role starts nothing
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    @(negedge clk);
    check(!busy && selN == 3'b111, "R8 no master start in slave role", {busy, selN}, 4'b0111);

    for (int i = 0; i < 6; i++) begin
      masterXfer(VEC[i][39:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // clamp leaves a previous larger divisor replaced by the minimum
    masterXfer(16'd7, 8'h04, 8'h3E, 8'hE1);
    masterXfer(16'd1, 8'h05, 8'hC7, 8'h18);

    // slave role, both phases and polarities
    slaveXfer(8'h00, 8'hB4, 8'h2D);
    slaveXfer(8'h03, 8'h4B, 8'hD2);
    slaveXfer(8'h02, 8'h01, 8'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule